// File: doc/BRIEF.md
# Serial LED-Driver Command Decoder

This block is the serial front end of a 24-channel LED driver. A 24-bit shift register takes one bit from `sdi` on every rising edge of the serial clock and presents its oldest bit on `sdo`, so several drivers can be chained. Commands are not sent as opcodes. The block counts the rising clock edges seen while `le` is high, and when `le` goes low it treats that count as a command key.

The keys latch display data, write the configuration or gain register, load a register image or the thermal flag into the shift register for read-out, or start one of three diagnostic phases. The analog current sources, the diagnostic comparators and the temperature sensor are outside the block. The block drives their control bits and takes the thermal flag in as a plain input.

A configuration bit enables an automatic sleep mode. Latching an all-zero display word puts the block to sleep, and latching a nonzero word wakes it. While it sleeps, every command except a data latch is dropped. A second configuration bit moves `sdo` updates to the falling clock edge, which helps when the clock and data paths in a chain have unequal delays.

Top module: `led_cmd_top`

## Requirements
- R1: Each rising `clk` edge shifts `sdi` into bit 0 of the 24-bit shift register. `sdo` shows bit 23, so bits leave in the order they entered.
- R2: The key is the number of rising edges seen with `le` high, counted from the `le` rising edge. It is executed on the first rising edge that finds `le` low again.
- R3: Key 1 or 2 copies the shift register, including the bit taken on the final edge with `le` high, to `dispData`.
- R4: Key 3 or 4 writes shift-register bits 11..0 to the 12-bit configuration register (`cfgBits`). Bits 23..12 are dropped. The register resets to zero.
- R5: Key 7 or 8 writes shift-register bits 17..0 to the gain register (`gainBits`). Red is in bits 5..0, green in 11..6 and blue in 17..12. Every gain bit resets to 1.
- R6: Key 5 or 6 loads {12'b0, cfgBits} into the shift register. Key 9 or 10 loads {6'b0, gainBits}. Key 14 loads {23'b0, thermFlag}. The next 24 clocks shift the image out on `sdo`, MSB first.
- R7: Keys 11, 12 and 13 give a one-cycle pulse on `diagOpen`, `diagShort` and `diagBoth` respectively.
- R8: Keys 15 and 16 do nothing. The counter stops at 16, so any longer `le` window also does nothing.
- R9: When configuration bit 6 is 1, a data latch of all zeros sets `sleep`, and a data latch with any 1 bit clears it.
- R10: While `sleep` is 1, every key other than 1 or 2 is ignored.
- R11: When configuration bit 7 is 1, `sdo` changes on the falling `clk` edge. When the bit is 0, `sdo` changes on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdi | input | 1 | Serial data in |
| le | input | 1 | Latch-enable / key window |
| thermFlag | input | 1 | Over-temperature flag from the sensor |
| sdo | output | 1 | Serial data out |
| dispData | output | 24 | Latched channel on/off word |
| cfgBits | output | 12 | Configuration register |
| gainBits | output | 18 | Gain register, three 6-bit fields |
| sleep | output | 1 | Auto-off state |
| diagOpen | output | 1 | Open-detection start pulse |
| diagShort | output | 1 | Short-detection start pulse |
| diagBoth | output | 1 | Combined detection start pulse |

## Verification
All register results (`dispData`, `cfgBits`, `gainBits`, `sleep` and the diagnostic pulses) change on the execution edge, the first rising edge after `le` falls. The bench checks them in the low phase that follows that edge, and checks the diagnostic pulses again one cycle later to confirm they have dropped. A read image is ready on `sdo` in the low phase after the execution edge. The bench compares one bit per low phase. With falling-edge retiming on, it also samples just after each rising edge to confirm that `sdo` has not yet moved.

// File: rtl/led_cmd_pkg.sv
package led_cmd_pkg;
  parameter int WORD_W  = 24;
  parameter int CFG_W   = 12;
  parameter int FIELD_W = 6;
  parameter int COLORS  = 3;
  parameter int KEY_MAX = 16;
  localparam int GAIN_W = FIELD_W * COLORS;
  localparam int KEY_W  = $clog2(KEY_MAX + 1);
  localparam int AUTO_OFF_BIT = 6;
  localparam int RETIME_BIT   = 7;

  typedef enum logic [3:0] {
    CMD_NONE, CMD_LATCH, CMD_WR_CFG, CMD_RD_CFG, CMD_WR_GAIN,
    CMD_RD_GAIN, CMD_OPEN, CMD_SHORT, CMD_BOTH, CMD_THERM
  } cmd_e;

  typedef struct packed {
    logic latch;
    logic wrCfg;
    logic wrGain;
    logic rdCfg;
    logic rdGain;
    logic rdTherm;
  } strobe_t;
endpackage

// File: rtl/led_cmd_ctrl.sv
module led_cmd_ctrl
  import led_cmd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    le,
  input  logic    shZero,
  input  logic    autoOffEn,
  output strobe_t strb,
  output logic    sleep,
  output logic    diagOpen,
  output logic    diagShort,
  output logic    diagBoth
);
  logic leQ;
  logic [KEY_W-1:0] keyCnt;
  logic execNow;
  cmd_e cmd;

  assign execNow = leQ && !le;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leQ    <= 1'b0;
      keyCnt <= '0;
    end else begin
      leQ <= le;
      if (le && !leQ)
        keyCnt <= KEY_W'(1);
      else if (le && keyCnt < KEY_W'(KEY_MAX))
        keyCnt <= keyCnt + KEY_W'(1);
    end
  end

  always_comb begin
    cmd = CMD_NONE;
    if (execNow) begin
      case (keyCnt)
        KEY_W'(1), KEY_W'(2):  cmd = CMD_LATCH;
        KEY_W'(3), KEY_W'(4):  cmd = CMD_WR_CFG;
        KEY_W'(5), KEY_W'(6):  cmd = CMD_RD_CFG;
        KEY_W'(7), KEY_W'(8):  cmd = CMD_WR_GAIN;
        KEY_W'(9), KEY_W'(10): cmd = CMD_RD_GAIN;
        KEY_W'(11):            cmd = CMD_OPEN;
        KEY_W'(12):            cmd = CMD_SHORT;
        KEY_W'(13):            cmd = CMD_BOTH;
        KEY_W'(14):            cmd = CMD_THERM;
        default:               cmd = CMD_NONE;
      endcase
      if (sleep && cmd != CMD_LATCH) cmd = CMD_NONE;
    end
  end

  always_comb begin
    strb         = '0;
    strb.latch   = (cmd == CMD_LATCH);
    strb.wrCfg   = (cmd == CMD_WR_CFG);
    strb.wrGain  = (cmd == CMD_WR_GAIN);
    strb.rdCfg   = (cmd == CMD_RD_CFG);
    strb.rdGain  = (cmd == CMD_RD_GAIN);
    strb.rdTherm = (cmd == CMD_THERM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep     <= 1'b0;
      diagOpen  <= 1'b0;
      diagShort <= 1'b0;
      diagBoth  <= 1'b0;
    end else begin
      if (strb.latch) sleep <= autoOffEn && shZero;
      diagOpen  <= (cmd == CMD_OPEN);
      diagShort <= (cmd == CMD_SHORT);
      diagBoth  <= (cmd == CMD_BOTH);
    end
  end

  // R8: the key counter never passes its ceiling
  assert_key_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    keyCnt <= KEY_W'(KEY_MAX));
  // R7: a diagnostic start lasts exactly one cycle
  assert_diag_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (diagOpen || diagShort || diagBoth) |=> !(diagOpen || diagShort || diagBoth));
  // R10: while asleep only the data latch strobe may fire
  assert_sleep_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !(strb.wrCfg || strb.wrGain || strb.rdCfg || strb.rdGain || strb.rdTherm));
  // R9: a nonzero latch always leaves the block awake
  assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.latch && !shZero) |=> !sleep);
endmodule

// File: rtl/led_cmd_datapath.sv
module led_cmd_datapath
  import led_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              thermFlag,
  input  strobe_t           strb,
  output logic              sdo,
  output logic              shZero,
  output logic              autoOffEn,
  output logic [WORD_W-1:0] dispData,
  output logic [CFG_W-1:0]  cfgBits,
  output logic [GAIN_W-1:0] gainBits
);
  logic [WORD_W-1:0] shReg;
  logic sdoNeg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      shReg <= '0;
    else if (strb.rdCfg)
      shReg <= WORD_W'(cfgBits);
    else if (strb.rdGain)
      shReg <= WORD_W'(gainBits);
    else if (strb.rdTherm)
      shReg <= WORD_W'(thermFlag);
    else
      shReg <= {shReg[WORD_W-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dispData <= '0;
      cfgBits  <= '0;
    end else begin
      if (strb.latch) dispData <= shReg;
      if (strb.wrCfg) cfgBits  <= shReg[CFG_W-1:0];
    end
  end

  for (genvar c = 0; c < COLORS; c++) begin : g_gain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        gainBits[c*FIELD_W +: FIELD_W] <= '1;
      else if (strb.wrGain)
        gainBits[c*FIELD_W +: FIELD_W] <= shReg[c*FIELD_W +: FIELD_W];
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sdoNeg <= 1'b0;
    else        sdoNeg <= shReg[WORD_W-1];
  end

  assign sdo       = cfgBits[RETIME_BIT] ? sdoNeg : shReg[WORD_W-1];
  assign shZero    = (shReg == '0);
  assign autoOffEn = cfgBits[AUTO_OFF_BIT];

  // R4: a config write stores the low word bits present at the strobe
  assert_cfg_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrCfg |=> cfgBits == $past(shReg[CFG_W-1:0]));
  // R5: gain only moves on a gain write
  assert_gain_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wrGain |=> $stable(gainBits));
  // R1: with no load strobe the register shifts by one
  assert_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.rdCfg || strb.rdGain || strb.rdTherm) |=>
      shReg[WORD_W-1:1] == $past(shReg[WORD_W-2:0]));
endmodule

// File: rtl/led_cmd_top.sv
module led_cmd_top
  import led_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              le,
  input  logic              thermFlag,
  output logic              sdo,
  output logic [WORD_W-1:0] dispData,
  output logic [CFG_W-1:0]  cfgBits,
  output logic [GAIN_W-1:0] gainBits,
  output logic              sleep,
  output logic              diagOpen,
  output logic              diagShort,
  output logic              diagBoth
);
  strobe_t strb;
  logic shZero;
  logic autoOffEn;

  led_cmd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .le(le), .shZero(shZero), .autoOffEn(autoOffEn),
    .strb(strb), .sleep(sleep), .diagOpen(diagOpen), .diagShort(diagShort),
    .diagBoth(diagBoth)
  );

  led_cmd_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .thermFlag(thermFlag), .strb(strb),
    .sdo(sdo), .shZero(shZero), .autoOffEn(autoOffEn), .dispData(dispData),
    .cfgBits(cfgBits), .gainBits(gainBits)
  );
endmodule

// File: tb/led_cmd_top_tb.sv
module led_cmd_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdi = 1'b0;
  logic le = 1'b0;
  logic thermFlag = 1'b0;
  logic sdo;
  logic [23:0] dispData;
  logic [11:0] cfgBits;
  logic [17:0] gainBits;
  logic sleep, diagOpen, diagShort, diagBoth;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  led_cmd_top u_dut (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .le(le), .thermFlag(thermFlag),
    .sdo(sdo), .dispData(dispData), .cfgBits(cfgBits), .gainBits(gainBits),
    .sleep(sleep), .diagOpen(diagOpen), .diagShort(diagShort), .diagBoth(diagBoth)
  );

  // key, word, expected dispData, cfgBits, gainBits
  localparam int NV = 9;
  localparam logic [82:0] VEC [NV] = '{
    {5'd2,  24'hA5A5A5, 24'hA5A5A5, 12'h000, 18'h3FFFF},
    {5'd4,  24'h123800, 24'hA5A5A5, 12'h800, 18'h3FFFF},
    {5'd8,  24'hFC0FC1, 24'hA5A5A5, 12'h800, 18'h00FC1},
    {5'd1,  24'h000001, 24'h000001, 12'h800, 18'h00FC1},
    {5'd15, 24'hFFFFFF, 24'h000001, 12'h800, 18'h00FC1},
    {5'd3,  24'h000A3F, 24'h000001, 12'hA3F, 18'h00FC1},
    {5'd7,  24'h03FFFF, 24'h000001, 12'hA3F, 18'h3FFFF},
    {5'd20, 24'h555555, 24'h000001, 12'hA3F, 18'h3FFFF},
    {5'd16, 24'h0F0F0F, 24'h000001, 12'hA3F, 18'h3FFFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // shift a word MSB first, le high on the last 'key' edges, then the execution edge
  task automatic sendKey(input int key, input logic [23:0] word);
    for (int j = 0; j < 24; j++) begin
      @(negedge clk);
      sdi = word[23-j];
      le  = (j >= 24 - key);
    end
    @(negedge clk);
    sdi = 1'b0;
    le  = 1'b0;
    @(posedge clk);
    @(negedge clk);
    #5;
  endtask

  // sample 24 bits of read-out; with retime also check sdo held after each rise
  task automatic readOut(input string req, input logic [23:0] exp, input bit retimed);
    for (int i = 0; i < 24; i++) begin
      if (i > 0) begin
        @(negedge clk);
        #5;
      end
      check(req, 32'(sdo), 32'(exp[23-i]));
      @(posedge clk);
      #5;
      if (retimed) check("R11 hold", 32'(sdo), 32'(exp[23-i]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    // reset state (R4, R5, R9)
    check("R3 reset disp", 32'(dispData), 32'h0);
    check("R4 reset cfg", 32'(cfgBits), 32'h0);
    check("R5 reset gain", 32'(gainBits), 32'h3FFFF);
    check("R9 reset sleep", 32'(sleep), 32'h0);

    // R2 R3 R4 R5 R8: table of keys
    for (int v = 0; v < NV; v++) begin
      sendKey(int'(VEC[v][82:78]), VEC[v][77:54]);
      check("R3 disp", 32'(dispData), 32'(VEC[v][53:30]));
      check("R4 cfg", 32'(cfgBits), 32'(VEC[v][29:18]));
      check("R5 gain", 32'(gainBits), 32'(VEC[v][17:0]));
    end

    // R6 read config and gain, thermal flag
    sendKey(5, 24'h0);
    readOut("R6 cfg read", 24'h000A3F, 1'b0);
    sendKey(8, 24'h02A5C3);
    sendKey(10, 24'h0);
    readOut("R6 gain read", 24'h02A5C3, 1'b0);
    thermFlag = 1'b1;
    sendKey(14, 24'h0);
    readOut("R6 therm read", 24'h000001, 1'b0);
    thermFlag = 1'b0;

    // R7 diagnostic pulses
    sendKey(11, 24'h0);
    check("R7 open", 32'({diagOpen, diagShort, diagBoth}), 32'b100);
    @(negedge clk); #5;
    check("R7 open drop", 32'({diagOpen, diagShort, diagBoth}), 32'b000);
    sendKey(12, 24'h0);
    check("R7 short", 32'({diagOpen, diagShort, diagBoth}), 32'b010);
    sendKey(13, 24'h0);
    check("R7 both", 32'({diagOpen, diagShort, diagBoth}), 32'b001);
    @(negedge clk); #5;
    check("R7 both drop", 32'({diagOpen, diagShort, diagBoth}), 32'b000);

    // R11 falling-edge retiming: cfg 0x2AA has bit 7 set, bit 6 clear
    sendKey(4, 24'h0002AA);
    sendKey(5, 24'h0);
    readOut("R11 retimed read", 24'h0002AA, 1'b1);
    sendKey(4, 24'h0);

    // R9 zero latch without auto-off stays awake
    sendKey(2, 24'h0);
    check("R9 no autooff", 32'(sleep), 32'h0);

    // R9 R10 auto-off: bit 6 set
    sendKey(4, 24'h000040);
    sendKey(2, 24'h0);
    check("R9 sleep enter", 32'(sleep), 32'h1);
    sendKey(4, 24'h000000);
    check("R10 cfg write ignored", 32'(cfgBits), 32'h040);
    sendKey(8, 24'h000000);
    check("R10 gain write ignored", 32'(gainBits), 32'h2A5C3);
    sendKey(11, 24'h0);
    check("R10 diag ignored", 32'({diagOpen, diagShort, diagBoth}), 32'b000);
    sendKey(5, 24'h0);
    readOut("R10 read ignored", 24'h000000, 1'b0);
    sendKey(1, 24'h0);
    check("R9 stay asleep", 32'(sleep), 32'h1);
    sendKey(2, 24'h800000);
    check("R9 wake", 32'(sleep), 32'h0);
    check("R3 wake data", 32'(dispData), 32'h800000);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule